// File: doc/BRIEF.md
# Minimum pulse-width filter

This block passes only the portion of an input pulse that outlasts a programmed number of clock cycles. The input level is brought into the clock domain through a chain of flops, and the rising edge of the synchronized level starts an internal countdown of the programmed length. While the countdown runs, the output stays low. If the input is still high when the countdown expires, the output goes high and follows the input until the input drops. A pulse that ends before the countdown expires leaves no trace on the output.

The output pulse therefore appears late by the threshold plus the synchronizer latency, and it is shorter than the input pulse by exactly the threshold. A threshold of zero turns the block into a plain synchronized pass-through. Typical uses are rejecting short glitches on a slow control line, and detecting that a strobe has lasted longer than some minimum.

Top module: `mpw_filter`

## Requirements
- R1: After reset the output is low. It stays low while the input is low, and it goes high only in response to an input pulse.
- R2: The input passes through SYNC_STAGES flops (default 2). For a threshold T and an input pulse whose first high sample is taken on clock edge 1, the output first reads high after edge T+SYNC_STAGES+1.
- R3: While the countdown started by a rising edge is running, the output is low.
- R4: Once the countdown has expired, the output stays high for as long as the input stays high. It goes low SYNC_STAGES edges after the first edge that samples the input low.
- R5: An input pulse that is sampled high on L consecutive edges gives an output pulse of exactly L-T cycles when L > T, and no output when L <= T.
- R6: If the input falls before the countdown expires, the pulse is dropped, the block returns to idle, and a following pulse is handled normally.
- R7: With a threshold of zero, the output is the synchronized input delayed by one further cycle, with the same length.
- R8: A new pulse is recognized only after the input has been sampled low. A single long input pulse gives one output pulse, and one low sample between two input pulses is enough to separate them.
- R9: The threshold is taken when the rising edge is detected. A change of the threshold input while a pulse is in progress has no effect on that pulse.
- R10: The largest threshold, 2^THR_W-1, is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Input level, may be asynchronous to clk |
| min_width | input | THR_W | Threshold in clock cycles |
| pulse_out | output | 1 | Filtered output level |

## Verification
The hardest situations to reach are those where the input and the countdown end on the same cycle or one cycle apart: L = T has to produce nothing, and L = T+1 has to produce a single cycle. The bench sweeps every threshold from 0 to 6 against every pulse length from 1 to 9, which covers both of these boundaries for each threshold. A reference model that tracks run lengths predicts every output sample. A separate run changes the threshold input in the middle of a countdown while the reference keeps the value that was in effect at the rising edge. Pulse pairs with a one-cycle gap exercise the path where the block leaves the pass state and a new pulse is recognized on the very next sample.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_PASS = 2'd2
   } mpw_state_e;
endpackage

// File: rtl/mpw_sync.sv
module mpw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mpw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mpw_edge.sv
module mpw_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;

   // R8: a rising edge cannot be reported on two cycles in a row
   assert_no_double_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/mpw_timer.sv
module mpw_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   generate
      if (W < 1) begin : g_bad_w
         $error("mpw_timer: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rem_q <= '0;
      else if (load)                   rem_q <= load_val;
      else if (dec && rem_q != '0)     rem_q <= rem_q - 1'b1;
   end

   assign zero = (rem_q == '0);

   // R5: each decrement removes exactly one cycle from the remaining count
   assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && dec && !zero) |=> (rem_q == $past(rem_q) - 1'b1));

   // R9: the count only changes on a load or a decrement
   assert_hold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(rem_q));
endmodule

// File: rtl/mpw_filter.sv
module mpw_filter
   import mpw_pkg::*;
#(
   parameter int THR_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_in,
   input  logic [THR_W-1:0] min_width,
   output logic             pulse_out
);
   generate
      if (THR_W < 1) begin : g_bad_thr
         $error("mpw_filter: THR_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mpw_filter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       sync_lvl;
   logic       rise;
   logic       tmr_load;
   logic       tmr_dec;
   logic       tmr_zero;
   logic [THR_W-1:0] tmr_val;
   mpw_state_e state_q, state_n;
   logic       out_q;

   mpw_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pulse_in),
      .q    (sync_lvl)
   );

   mpw_edge i_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .level(sync_lvl),
      .rise (rise)
   );

   mpw_timer #(.W(THR_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .dec     (tmr_dec),
      .zero    (tmr_zero)
   );

   assign tmr_val = min_width - 1'b1;

   always_comb begin
      state_n  = state_q;
      tmr_load = 1'b0;
      tmr_dec  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (rise) begin
               if (min_width == '0) begin
                  state_n = ST_PASS;
               end else begin
                  state_n  = ST_HOLD;
                  tmr_load = 1'b1;
               end
            end
         end
         ST_HOLD: begin
            if (!sync_lvl)     state_n = ST_IDLE;
            else if (tmr_zero) state_n = ST_PASS;
            else               tmr_dec = 1'b1;
         end
         ST_PASS: begin
            if (!sync_lvl) state_n = ST_IDLE;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         out_q   <= 1'b0;
      end else begin
         state_q <= state_n;
         out_q   <= (state_n == ST_PASS);
      end
   end

   assign pulse_out = out_q;

   // R1: the output can only rise after the synchronized input was high
   assert_rise_from_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> $past(sync_lvl));

   // R3: no output while the countdown runs
   assert_blocked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD) |-> !out_q);

   // R4: a low synchronized input ends an active output on the next cycle
   assert_follow_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q && !sync_lvl) |=> !out_q);

   // R6: an input that drops during the countdown returns the block to idle
   assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && !sync_lvl) |=> (state_q == ST_IDLE && !out_q));

   // R7: a zero threshold passes a fresh edge straight through
   assert_zero_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && rise && min_width == '0) |=> out_q);
endmodule

// File: tb/test_mpw_filter.sv
module test_mpw_filter;
   localparam int THR_W = 8;
   localparam int SYNC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             din = 1'b0;
   logic [THR_W-1:0] thr = '0;
   logic             dout;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit mon_en = 1'b0;
   int tmod = 0;
   int rl = 0, rl_d1 = 0, rl_d2 = 0;

   always #4 clk = ~clk;

   mpw_filter #(.THR_W(THR_W), .SYNC_STAGES(SYNC)) i_mpw_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_in (din),
      .min_width(thr),
      .pulse_out(dout)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // run-length reference: output after edge e is high when the input run
   // seen at edge e-2 has lasted at least T+1 samples
   always @(posedge clk) begin
      if (!rst_n) begin
         rl <= 0; rl_d1 <= 0; rl_d2 <= 0;
      end else begin
         rl    <= din ? rl + 1 : 0;
         rl_d1 <= rl;
         rl_d2 <= rl_d1;
      end
   end

   always @(negedge clk) begin
      if (mon_en) begin
         int e;
         e = (rl_d2 >= tmod + 1) ? 1 : 0;
         if (e == 1)         chk(dout == 1'b1, "R4 per-cycle", dout, e);
         else if (rl_d2 > 0) chk(dout == 1'b0, "R3 per-cycle", dout, e);
         else                chk(dout == 1'b0, "R1 per-cycle", dout, e);
      end
   end

   task automatic set_thr(input int t);
      @(negedge clk);
      thr  = t[THR_W-1:0];
      tmod = t;
   endtask

   // one pulse of L samples; checks first-high index and output length
   task automatic run_pulse(input int t, input int l, input string tag);
      int first = 0;
      int highs = 0;
      set_thr(t);
      @(negedge clk);
      din = 1'b1;
      for (int j = 1; j <= l + t + 6; j++) begin
         @(negedge clk);
         if (dout) begin
            highs++;
            if (first == 0) first = j;
         end
         if (j == l) din = 1'b0;
      end
      chk(highs == ((l > t) ? l - t : 0), {tag, " R5 length"}, highs, (l > t) ? l - t : 0);
      chk(first == ((l > t) ? t + SYNC + 1 : 0), {tag, " R2 first high"}, first,
          (l > t) ? t + SYNC + 1 : 0);
   endtask

   // two pulses separated by a gap of g low samples
   task automatic run_pair(input int t, input int l1, input int g, input int l2);
      int highs = 0;
      int rises = 0;
      bit prev = 1'b0;
      int n = l1 + g + l2;
      int exp_h = ((l1 > t) ? l1 - t : 0) + ((l2 > t) ? l2 - t : 0);
      int exp_r = ((l1 > t) ? 1 : 0) + ((l2 > t) ? 1 : 0);
      set_thr(t);
      @(negedge clk);
      din = 1'b1;
      for (int j = 1; j <= n + 8; j++) begin
         @(negedge clk);
         if (dout) highs++;
         if (dout && !prev) rises++;
         prev = dout;
         if (j == l1)          din = 1'b0;
         else if (j == l1 + g) din = 1'b1;
         else if (j == n)      din = 1'b0;
      end
      chk(highs == exp_h, "R6/R8 pair length", highs, exp_h);
      chk(rises == exp_r, "R8 pair count", rises, exp_r);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(dout == 1'b0, "R1 in reset", dout, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      mon_en = 1'b1;
      repeat (10) @(negedge clk);
      chk(dout == 1'b0, "R1 idle after reset", dout, 0);

      // full sweep of threshold against pulse length (R2 R3 R4 R5 R6 R7)
      for (int t = 0; t <= 6; t++)
         for (int l = 1; l <= 9; l++)
            run_pulse(t, l, (t == 0) ? "R7 sweep" : "sweep");

      // boundary pulses around the threshold
      run_pulse(3, 3, "R6 equal");
      run_pulse(3, 4, "R5 one-over");

      // one-sample gaps and aborted first pulses
      run_pair(0, 4, 1, 3);
      run_pair(2, 5, 1, 5);
      run_pair(3, 2, 1, 6);
      run_pair(4, 9, 2, 3);

      // R9: threshold changes during the countdown are ignored
      begin
         int highs = 0;
         set_thr(4);
         @(negedge clk);
         din = 1'b1;
         for (int j = 1; j <= 18; j++) begin
            @(negedge clk);
            if (dout) highs++;
            if (j == 3) thr = 8'd1;
            if (j == 10) din = 1'b0;
         end
         chk(highs == 6, "R9 lowered mid-pulse", highs, 6);
         highs = 0;
         set_thr(4);
         @(negedge clk);
         din = 1'b1;
         for (int j = 1; j <= 18; j++) begin
            @(negedge clk);
            if (dout) highs++;
            if (j == 4) thr = 8'd9;
            if (j == 10) din = 1'b0;
         end
         chk(highs == 6, "R9 raised mid-pulse", highs, 6);
      end

      // R10: largest threshold
      run_pulse(255, 255, "R10 max equal");
      run_pulse(255, 258, "R10 max over");

      // R8: a long pulse yields one output pulse
      run_pair(1, 40, 1, 1);

      set_thr(0);
      repeat (10) @(negedge clk);
      chk(dout == 1'b0, "R1 final idle", dout, 0);

      done = 1'b1;
      mon_en = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule